// File: doc/BRIEF.md
# Halfword Multiply-Accumulate Unit with Saturation

This block is the arithmetic core behind a set of DSP-style instruction extensions. Each issued operation picks one half of each of two source words. It multiplies the two halves as signed or unsigned numbers. It then either returns the product alone, adds it to an accumulator value, or subtracts it from that value. Accumulating operations form an intermediate one bit wider than the data path. That intermediate is narrowed to the data width in one of two ways: modulo (keep the low bits) or saturating (clamp to the representable range).

The unit is a two-stage pipeline. The first stage selects the halfwords and multiplies them. The second stage adds or subtracts and then narrows the result. One operation may enter on every clock. Results leave in issue order two clocks later, flagged by a valid bit. A synchronous reset empties the pipeline. Register reads and write-back, flag updates and instruction decode belong to the surrounding core.

Top module: `hw_mac`

## Requirements
- R1: While `rst` is high at a clock edge, both pipeline valid bits clear; `out_valid` is low from the first edge after reset until an operation has travelled the full pipeline.
- R2: An operation presented with `in_valid` high at edge k appears with `out_valid` high after edge k+2. Back-to-back operations leave in issue order, and cycles with `in_valid` low produce `out_valid` low two edges later.
- R3: `a_hi`/`b_hi` at 0 select bits [DW/2-1:0] of `src_a`/`src_b`, and at 1 select bits [DW-1:DW/2]. The unselected halves have no effect.
- R4: With `is_signed` high, the halves and the accumulator are two's-complement numbers; with it low, they are unsigned. The product is the exact DW-bit product of the two halves.
- R5: `op_sel` code 2'b00 adds the product to `acc_in` and code 2'b01 subtracts it. Both form a DW+1-bit intermediate.
- R6: `op_sel` codes 2'b10 and 2'b11 return the product alone. `acc_in` and `saturate` have no effect for these codes.
- R7: With `saturate` low, an accumulating operation returns the low DW bits of the intermediate.
- R8: With `saturate` high and `is_signed` high, an intermediate above 2^(DW-1)-1 gives 0x7F..F, and one below -2^(DW-1) gives 0x80..0.
- R9: With `saturate` high and `is_signed` low, a sum above 2^DW-1 gives all ones, and a difference below zero gives zero.
- R10: With `saturate` high, an intermediate that fits in DW bits is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation issued this cycle |
| src_a | input | DW | First source word |
| src_b | input | DW | Second source word |
| acc_in | input | DW | Accumulator value |
| op_sel | input | 2 | 00 add, 01 subtract, 1x product only |
| a_hi | input | 1 | Take the upper half of src_a |
| b_hi | input | 1 | Take the upper half of src_b |
| is_signed | input | 1 | Two's-complement operands |
| saturate | input | 1 | Clamp instead of wrapping |
| out_valid | output | 1 | Result valid |
| result | output | DW | Narrowed result |

## Verification
A wrong product register or a wrong stage-1 control bit corrupts `result` on the very next `out_valid` cycle. A fault in the extension bit or the overflow test shows only near the range limits, as a wrapped value where a clamp belongs, or the reverse. A valid bit that is stuck or delayed shows at once as `out_valid` out of step with the issue pattern two cycles earlier. The bench therefore sweeps every mode combination with operands that reach both range ends.

// File: rtl/hw_mac.sv
module hw_mac #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [DW-1:0] acc_in,
  input  logic [1:0]    op_sel,
  input  logic          a_hi,
  input  logic          b_hi,
  input  logic          is_signed,
  input  logic          saturate,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  // stage 1: halfword pick and multiply
  logic [HW-1:0] ha, hb;
  logic [DW-1:0] xa, xb;
  assign ha = a_hi ? src_a[DW-1:HW] : src_a[HW-1:0];
  assign hb = b_hi ? src_b[DW-1:HW] : src_b[HW-1:0];
  assign xa = {{HW{is_signed & ha[HW-1]}}, ha};
  assign xb = {{HW{is_signed & hb[HW-1]}}, hb};

  logic          s1_v, s1_sgn, s1_sat, s1_neg, s1_mul;
  logic [DW-1:0] s1_prod, s1_acc;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= in_valid;
    if (in_valid) begin
      s1_prod <= xa * xb;
      s1_acc  <= acc_in;
      s1_sgn  <= is_signed;
      s1_sat  <= saturate;
      s1_neg  <= op_sel[0];
      s1_mul  <= op_sel[1];
    end
  end

  // stage 2: accumulate and narrow
  logic [DW:0]   pe, ae, mid;
  logic          ovf;
  logic [DW-1:0] clamp, narrow;
  assign pe  = {s1_sgn & s1_prod[DW-1], s1_prod};
  assign ae  = {s1_sgn & s1_acc[DW-1], s1_acc};
  assign mid = s1_neg ? ae - pe : ae + pe;
  assign ovf = s1_sgn ? (mid[DW] != mid[DW-1]) : mid[DW];
  assign clamp = s1_sgn ? (mid[DW] ? SMIN : SMAX)
                        : (s1_neg ? '0 : '1);
  assign narrow = s1_mul ? s1_prod : ((s1_sat && ovf) ? clamp : mid[DW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_v;
    if (s1_v) result <= narrow;
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !out_valid && !s1_v);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    s1_v |=> out_valid);
  a_r2_bubble_follows: assert property (@(posedge clk) disable iff (rst)
    !s1_v |=> !out_valid);
  a_r6_product_only: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_mul) |=> result == $past(s1_prod));
  a_r9_unsigned_add_floor: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !s1_mul && s1_sat && !s1_sgn && !s1_neg) |=> result >= $past(s1_acc));
  a_r9_unsigned_sub_ceiling: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !s1_mul && s1_sat && !s1_sgn && s1_neg) |=> result <= $past(s1_acc));
  a_r8_signed_add_floor: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !s1_mul && s1_sat && s1_sgn && !s1_neg && !s1_prod[DW-1])
    |=> $signed(result) >= $signed($past(s1_acc)));
endmodule

// File: tb/hw_mac_tb.sv
module hw_mac_tb;
  localparam int DW = 8;
  localparam int HW = DW / 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, in_valid, a_hi, b_hi, is_signed, saturate, out_valid;
  logic [1:0]    op_sel;
  logic [DW-1:0] src_a, src_b, acc_in, result;

  hw_mac #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .op_sel(op_sel), .a_hi(a_hi), .b_hi(b_hi),
    .is_signed(is_signed), .saturate(saturate), .out_valid(out_valid), .result(result));

  int checks = 0;
  int fails  = 0;

  // expectations in flight: index 1 = driven one negedge ago, 2 = two ago
  logic          pv1 = 1'b0, pv2 = 1'b0;
  logic [DW-1:0] pr1 = '0, pr2 = '0;

  function automatic int half(input logic [DW-1:0] w, input logic hi, input logic sg);
    int v;
    v = hi ? int'(w[DW-1:HW]) : int'(w[HW-1:0]);
    if (sg && v >= (1 << (HW-1))) v = v - (1 << HW);
    return v;
  endfunction

  function automatic logic [DW-1:0] model(input logic [DW-1:0] a, b, acc,
      input logic [1:0] op, input logic ah, bh, sg, sat);
    int p, c, v, lo, hi;
    p = half(a, ah, sg) * half(b, bh, sg);
    if (op[1]) return DW'(p);
    c = int'(acc);
    if (sg && c >= (1 << (DW-1))) c = c - (1 << DW);
    v = op[0] ? c - p : c + p;
    lo = sg ? -(1 << (DW-1)) : 0;
    hi = sg ? (1 << (DW-1)) - 1 : (1 << DW) - 1;
    if (sat && v > hi) v = hi;
    if (sat && v < lo) v = lo;
    return DW'(v);
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: check outputs due now, then drive the next operation
  task automatic step(input logic v, input logic [DW-1:0] a, b, acc,
      input logic [1:0] op, input logic ah, bh, sg, sat, input string tag);
    @(negedge clk);
    check({tag, " R2 valid"}, DW'(out_valid), DW'(pv2));
    if (pv2) check(tag, result, pr2);
    pv2 = pv1; pr2 = pr1;
    pv1 = v;
    pr1 = model(a, b, acc, op, ah, bh, sg, sat);
    in_valid = v; src_a = a; src_b = b; acc_in = acc; op_sel = op;
    a_hi = ah; b_hi = bh; is_signed = sg; saturate = sat;
  endtask

  task automatic run_main;
    rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; acc_in = '0;
    op_sel = 2'b00; a_hi = 0; b_hi = 0; is_signed = 0; saturate = 0;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", DW'(out_valid), '0);
    rst = 1'b0;
    // directed corners (DW=8: signed range -128..127)
    step(1, 8'h07, 8'h07, 8'h7F, 2'b00, 0, 0, 1, 1, "R8 pos clamp");
    step(1, 8'h08, 8'h07, 8'h80, 2'b00, 0, 0, 1, 1, "R8 neg clamp");
    step(1, 8'h07, 8'h07, 8'h7F, 2'b00, 0, 0, 1, 0, "R7 signed wrap");
    step(1, 8'h0F, 8'h0F, 8'hFF, 2'b00, 0, 0, 0, 1, "R9 unsigned top clamp");
    step(1, 8'h0F, 8'h0F, 8'h10, 2'b01, 0, 0, 0, 1, "R9 unsigned zero clamp");
    step(0, 8'h00, 8'h00, 8'h00, 2'b00, 0, 0, 0, 0, "R2 bubble");
    step(1, 8'h30, 8'h05, 8'h10, 2'b00, 1, 0, 0, 1, "R3 R10 high half a");
    step(1, 8'hF3, 8'h5E, 8'h00, 2'b10, 0, 1, 1, 1, "R6 product only");
    step(1, 8'hF3, 8'h5E, 8'h55, 2'b11, 0, 1, 1, 0, "R6 R4 product only acc ignored");
    step(1, 8'h88, 8'h88, 8'h00, 2'b10, 1, 0, 1, 0, "R4 min times min");
    step(1, 8'h02, 8'h03, 8'h0A, 2'b01, 0, 0, 1, 1, "R5 subtract");
    // sweep: all op codes, half picks, signedness and saturation
    for (int m = 0; m < 64; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 6; k++) begin
          logic [DW-1:0] bb, cc;
          bb = DW'(a * 37 + k * 53 + m * 3);
          cc = DW'(a * 11 + k * 97 + m * 5 + (k == 0 ? 127 : 0));
          step((k != 5), DW'(a), bb, cc, m[1:0], m[2], m[3], m[4], m[5],
               "R3 R4 R5 R7 R8 R9 R10 sweep");
        end
      end
    end
    repeat (3) step(0, '0, '0, '0, 2'b00, 0, 0, 0, 0, "R2 drain");
    // reset mid-stream clears the pipeline
    step(1, 8'h11, 8'h11, 8'h00, 2'b00, 0, 0, 0, 0, "R1 pre-reset");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset flushes pipeline", DW'(out_valid), '0);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule